// File: doc/BRIEF.md
# Keyed Flash Control Register Block

This block sits between a simple peripheral bus and an on-chip flash array. It holds three password-guarded control words: one chooses the flash operation, one sets up the timing clock, and one holds status and emergency control. A write to any of the three takes effect only when the upper byte carries the unlock key A5h. Every read shows 96h in the upper byte. When the flash-side requester makes a write access, the block runs the operation that the stored operation bits select. The operation is a program, a segment erase, a main-memory mass erase or a whole-array erase. While it runs, the block raises `busy` and shows the running operation on `op_code`. It keeps `busy` up for a set number of timing-clock ticks for each kind of operation.

The timing clock is a one-cycle enable, `ftg_tick`. It comes from one of three source enables, chosen by a 2-bit selector, and is divided by a 6-bit field plus one (1 to 64). The block raises the access-violation flag in place of acting in these cases: an illegal mix of operation bits, an operation or timing word rewritten while busy, or a flash write with no operation armed. A write with the wrong key sets a separate key-violation flag and pulses `rst_req`.

The flash access port is a valid/ready stream. A write beat is taken when `fa_valid && fa_ready`. `fa_ready` is low for writes while busy, so the requester must hold the write until it rises. Reads are always ready. During an operation, a read returns the self-jump opcode 3FFFh in place of array data, so a processor fetching from flash spins until `busy` falls.

Top module: `flash_ctl_regs`

## Requirements
- R1: After reset the operation word (byte address 128h) reads 9600h, the timing word (12Ah) reads 9642h (source select 1, divider field 2), the status word (12Ch) reads 9600h, `busy` is 0 and `op_code` is 0.
- R2: A bus write to any of the three words with an upper byte other than A5h changes no word. It sets the key-violation flag (status bit 1), and `rst_req` is high in the single cycle after that write's clock edge.
- R3: Reads return 96h in bits 15:8. In the operation word only bit 1 (segment erase), bit 2 (mass erase), bit 6 (write enable) and bit 7 (segment-write) can read 1. In the status word bit 0 is `busy`, bit 1 is key violation, bit 2 is access violation, and all other bits read 0.
- R4: An operation-word write is accepted only when bits {7,6,2,1} hold one of these patterns: 0000, 0100, 1100, 0001, 0010 or 0011. Any other pattern sets the access-violation flag (status bit 2) and leaves the word unchanged.
- R5: A keyed write to the operation word or the timing word while `busy` is 1 sets the access-violation flag and leaves that word unchanged.
- R6: A flash write beat taken while the operation word has bits 7, 6, 2 and 1 all at 0 sets the access-violation flag and starts nothing.
- R7: A flash write beat taken with an armed operation raises `busy` for exactly WR_TICKS, SEG_TICKS or MASS_TICKS timing ticks. `op_code` is 1 for a write, 2 for a segment erase, 3 for a main mass erase (bit 2 alone) and 4 for a full erase (bits 2 and 1). When an erase finishes, bits 2 and 1 clear. A write leaves bit 6 set.
- R8: Timing-word bits 7:6 select the tick source: 0 selects `aclk_en`, 1 selects `mclk_en`, 2 and 3 select `smclk_en`. `ftg_tick` fires once every (bits 5:0)+1 enables of the chosen source.
- R9: A keyed status-word write with bit 5 set ends any running operation, so `busy` is 0 from the next cycle. It clears operation bits 2 and 1 and restarts the tick divider from zero.
- R10: `fa_rdata_out` equals 3FFFh while `busy` is 1, and equals `fa_rdata_in` otherwise.
- R11: `fa_ready` is 0 when `fa_we` is 1 and `busy` is 1. It is 1 in every other case.
- R12: A keyed status-word write loads bits 1 and 2 from the written data. A violation that happens in the same cycle wins, and its flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-up reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Bus write (1) or read (0) |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 16 | Write data, key in bits 15:8 |
| bus_rdata | output | 16 | Read data for the addressed word |
| aclk_en | input | 1 | Auxiliary clock enable, tick source 0 |
| mclk_en | input | 1 | Main clock enable, tick source 1 |
| smclk_en | input | 1 | Subsystem clock enable, tick sources 2 and 3 |
| fa_valid | input | 1 | Flash access beat valid |
| fa_we | input | 1 | Flash access is a write |
| fa_ready | output | 1 | Flash access beat can be taken |
| fa_rdata_in | input | 16 | Data read from the flash array |
| fa_rdata_out | output | 16 | Read data returned to the requester |
| busy | output | 1 | Operation in progress |
| ftg_tick | output | 1 | Divided timing-clock enable |
| op_code | output | 3 | Running operation, 0 when idle |
| rst_req | output | 1 | One-cycle reset request after a bad key |

## Verification
The access-violation flag has two writers that can act in the same cycle. One is a violation, for example a flash write with no operation armed. The other is a software write to the status word that clears the flag. The bench provokes this by driving a keyed status-word write of zero in the very cycle that an unarmed flash write beat is taken. It then expects status bit 2 to read 1 afterwards, and 0 only after a later clear that stands alone. A second same-cycle case is an emergency exit landing in the middle of a mass erase. The bench judges it by `busy` dropping on the next sample and by the erase bits reading 0.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  localparam logic [7:0]  KEY_WR   = 8'hA5;
  localparam logic [7:0]  KEY_RD   = 8'h96;
  localparam logic [15:0] JMP_SELF = 16'h3FFF;

  // operation word bit positions (decoded by the flash-side logic)
  localparam int B_ERASE  = 1;
  localparam int B_MERASE = 2;
  localparam int B_WREN   = 6;
  localparam int B_SEGWR  = 7;

  // status word bit positions
  localparam int S_BUSY  = 0;
  localparam int S_KEYV  = 1;
  localparam int S_ACCV  = 2;
  localparam int S_EXIT  = 5;

  // timing word reset: source 1, divider field 2
  localparam logic [7:0] TIM_RST = 8'h42;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_WRITE = 3'd1,
    OP_SEG   = 3'd2,
    OP_MAIN  = 3'd3,
    OP_ALL   = 3'd4
  } op_e;
endpackage

// File: rtl/fcr_ctl_check.sv
module fcr_ctl_check
  import fcr_pkg::*;
(
  input  logic [3:0] bits_i,   // {segwr, wren, merase, erase}
  output logic       legal_o,
  output op_e        op_o
);
  always_comb begin
    legal_o = 1'b1;
    op_o    = OP_IDLE;
    unique case (bits_i)
      4'b0000: op_o = OP_IDLE;
      4'b0100: op_o = OP_WRITE;
      4'b1100: op_o = OP_WRITE;
      4'b0001: op_o = OP_SEG;
      4'b0010: op_o = OP_MAIN;
      4'b0011: op_o = OP_ALL;
      default: legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fcr_clkdiv.sv
module fcr_clkdiv #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [1:0]       sel_i,
  input  logic [DIV_W-1:0] ratio_m1_i,
  input  logic [2:0]       src_en_i,   // {smclk, mclk, aclk}
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             src;

  always_comb begin
    unique case (sel_i)
      2'd0:    src = src_en_i[0];
      2'd1:    src = src_en_i[1];
      default: src = src_en_i[2];
    endcase
  end

  assign tick_o = src && (cnt_q == ratio_m1_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (src)     cnt_q <= (cnt_q >= ratio_m1_i) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/fcr_seq.sv
module fcr_seq
  import fcr_pkg::*;
#(
  parameter int WR_TICKS   = 4,
  parameter int SEG_TICKS  = 8,
  parameter int MASS_TICKS = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic abort_i,
  input  logic start_i,
  input  op_e  start_op_i,
  input  logic tick_i,
  output logic busy_o,
  output op_e  op_o,
  output logic done_o
);
  localparam int MAX_A  = (WR_TICKS > SEG_TICKS) ? WR_TICKS : SEG_TICKS;
  localparam int MAX_T  = (MAX_A > MASS_TICKS) ? MAX_A : MASS_TICKS;
  localparam int CNT_W  = $clog2(MAX_T + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;
  logic             busy_q;
  op_e              op_q;

  always_comb begin
    unique case (start_op_i)
      OP_WRITE: load_val = CNT_W'(WR_TICKS);
      OP_SEG:   load_val = CNT_W'(SEG_TICKS);
      default:  load_val = CNT_W'(MASS_TICKS);
    endcase
  end

  assign done_o = busy_q && tick_i && (cnt_q == CNT_W'(1)) && !abort_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= OP_IDLE;
      cnt_q  <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      op_q   <= OP_IDLE;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      op_q   <= start_op_i;
      cnt_q  <= load_val;
    end else if (busy_q && tick_i) begin
      if (cnt_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        op_q   <= OP_IDLE;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign op_o   = op_q;
endmodule

// File: rtl/flash_ctl_regs.sv
module flash_ctl_regs
  import fcr_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int DIV_W      = 6,
  parameter int WR_TICKS   = 4,
  parameter int SEG_TICKS  = 8,
  parameter int MASS_TICKS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              aclk_en,
  input  logic              mclk_en,
  input  logic              smclk_en,
  input  logic              fa_valid,
  input  logic              fa_we,
  output logic              fa_ready,
  input  logic [15:0]       fa_rdata_in,
  output logic [15:0]       fa_rdata_out,
  output logic              busy,
  output logic              ftg_tick,
  output logic [2:0]        op_code,
  output logic              rst_req
);
  localparam logic [ADDR_W-1:0] A_OPW = ADDR_W'(12'h128);
  localparam logic [ADDR_W-1:0] A_TIM = ADDR_W'(12'h12A);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(12'h12C);
  localparam int TIM_W = DIV_W + 2;

  logic [3:0]       opw_q;     // {segwr, wren, merase, erase}
  logic [TIM_W-1:0] tim_q;     // {sel[1:0], ratio_m1}
  logic             keyv_q, accv_q, rst_req_q;

  // bus decode
  logic wr_opw, wr_tim, wr_sts, key_ok, key_bad;
  logic ok_opw, ok_tim, ok_sts, emex_hit;
  assign wr_opw  = bus_sel && bus_we && (bus_addr == A_OPW);
  assign wr_tim  = bus_sel && bus_we && (bus_addr == A_TIM);
  assign wr_sts  = bus_sel && bus_we && (bus_addr == A_STS);
  assign key_ok  = (bus_wdata[15:8] == KEY_WR);
  assign key_bad = (wr_opw || wr_tim || wr_sts) && !key_ok;
  assign ok_opw  = wr_opw && key_ok;
  assign ok_tim  = wr_tim && key_ok;
  assign ok_sts  = wr_sts && key_ok;
  assign emex_hit = ok_sts && bus_wdata[S_EXIT];

  // legality of the new and of the stored operation bits
  logic [3:0] new_bits;
  logic       new_legal, cur_legal;
  op_e        new_op, cur_op;
  assign new_bits = {bus_wdata[B_SEGWR], bus_wdata[B_WREN],
                     bus_wdata[B_MERASE], bus_wdata[B_ERASE]};

  fcr_ctl_check u_chk_new (.bits_i(new_bits), .legal_o(new_legal), .op_o(new_op));
  fcr_ctl_check u_chk_cur (.bits_i(opw_q),    .legal_o(cur_legal), .op_o(cur_op));

  // timing tick
  fcr_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (emex_hit),
    .sel_i     (tim_q[TIM_W-1 -: 2]),
    .ratio_m1_i(tim_q[DIV_W-1:0]),
    .src_en_i  ({smclk_en, mclk_en, aclk_en}),
    .tick_o    (ftg_tick)
  );

  // operation sequencing
  logic fa_wr_take, start, seq_done;
  op_e  seq_op;
  assign fa_ready   = !(busy && fa_we);
  assign fa_wr_take = fa_valid && fa_we && fa_ready;
  assign start      = fa_wr_take && cur_legal && (cur_op != OP_IDLE) && !emex_hit;

  fcr_seq #(
    .WR_TICKS  (WR_TICKS),
    .SEG_TICKS (SEG_TICKS),
    .MASS_TICKS(MASS_TICKS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort_i   (emex_hit),
    .start_i   (start),
    .start_op_i(cur_op),
    .tick_i    (ftg_tick),
    .busy_o    (busy),
    .op_o      (seq_op),
    .done_o    (seq_done)
  );
  assign op_code = seq_op;

  // violations
  logic v_busy, v_combo, v_noop, v_any;
  assign v_busy  = (ok_opw || ok_tim) && busy;
  assign v_combo = ok_opw && !busy && !new_legal;
  assign v_noop  = fa_wr_take && (cur_op == OP_IDLE);
  assign v_any   = v_busy || v_combo || v_noop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opw_q <= '0;
    end else if (emex_hit) begin
      opw_q[1:0] <= 2'b00;
    end else if (ok_opw && !busy && new_legal) begin
      opw_q <= new_bits;
    end else if (seq_done) begin
      opw_q[1:0] <= 2'b00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tim_q <= TIM_W'(TIM_RST);
    else if (ok_tim && !busy)  tim_q <= bus_wdata[TIM_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accv_q    <= 1'b0;
      keyv_q    <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= key_bad;
      if (v_any)        accv_q <= 1'b1;
      else if (ok_sts)  accv_q <= bus_wdata[S_ACCV];
      if (key_bad)      keyv_q <= 1'b1;
      else if (ok_sts)  keyv_q <= bus_wdata[S_KEYV];
    end
  end
  assign rst_req = rst_req_q;

  // read path
  logic [7:0] opw_byte, sts_byte, tim_byte;
  always_comb begin
    opw_byte = '0;
    opw_byte[B_SEGWR]  = opw_q[3];
    opw_byte[B_WREN]   = opw_q[2];
    opw_byte[B_MERASE] = opw_q[1];
    opw_byte[B_ERASE]  = opw_q[0];
    sts_byte = '0;
    sts_byte[S_BUSY] = busy;
    sts_byte[S_KEYV] = keyv_q;
    sts_byte[S_ACCV] = accv_q;
    tim_byte = 8'(tim_q);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      if (bus_addr == A_OPW)      bus_rdata = {KEY_RD, opw_byte};
      else if (bus_addr == A_TIM) bus_rdata = {KEY_RD, tim_byte};
      else if (bus_addr == A_STS) bus_rdata = {KEY_RD, sts_byte};
    end
  end

  assign fa_rdata_out = busy ? JMP_SELF : fa_rdata_in;
endmodule

// File: rtl/fcr_checker.sv
module fcr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic [2:0] op_code,
  input logic       rst_req,
  input logic       keyv,
  input logic       fa_valid,
  input logic       fa_we,
  input logic       ftg_tick,
  input logic       emex,
  input logic [7:0] tim
);
  p_keyv_with_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> keyv);

  p_busy_matches_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (op_code != 3'd0));

  p_start_needs_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(fa_valid && fa_we));

  p_fall_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(ftg_tick || emex));

  p_timing_held_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(tim));

  p_exit_idles_r9: assert property (@(posedge clk) disable iff (!rst_n)
    emex |=> !busy);
endmodule

bind flash_ctl_regs fcr_checker u_fcr_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .op_code (op_code),
  .rst_req (rst_req),
  .keyv    (keyv_q),
  .fa_valid(fa_valid),
  .fa_we   (fa_we),
  .ftg_tick(ftg_tick),
  .emex    (emex_hit),
  .tim     (tim_byte)
);

// File: tb/flash_ctl_regs_tb_top.sv
module flash_ctl_regs_tb_top;
  localparam int WRT = 4, SEGT = 8, MAST = 12;
  localparam logic [8:0] A_OPW = 9'h128, A_TIM = 9'h12A, A_STS = 9'h12C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_we = 0;
  logic [8:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic aclk_en = 0, mclk_en = 1, smclk_en = 0;
  logic fa_valid = 0, fa_we = 0, fa_ready;
  logic [15:0] fa_rdata_in = 16'h1234, fa_rdata_out;
  logic busy, ftg_tick, rst_req;
  logic [2:0] op_code;

  int nchk = 0, nfail = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  flash_ctl_regs #(.ADDR_W(9), .DIV_W(6), .WR_TICKS(WRT), .SEG_TICKS(SEGT),
                   .MASS_TICKS(MAST)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .aclk_en(aclk_en), .mclk_en(mclk_en), .smclk_en(smclk_en),
    .fa_valid(fa_valid), .fa_we(fa_we), .fa_ready(fa_ready),
    .fa_rdata_in(fa_rdata_in), .fa_rdata_out(fa_rdata_out), .busy(busy),
    .ftg_tick(ftg_tick), .op_code(op_code), .rst_req(rst_req));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench model of the legal operation patterns (bits 7,6,2,1)
  function automatic bit exp_legal(input logic [7:0] b);
    logic [3:0] n;
    n = {b[7], b[6], b[2], b[1]};
    return n inside {4'b0000, 4'b0100, 4'b1100, 4'b0001, 4'b0010, 4'b0011};
  endfunction

  function automatic logic [7:0] opw_view(input logic [7:0] b);
    return b & 8'hC6;
  endfunction

  task automatic bwr(input logic [8:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic brd(input logic [8:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic fwr();
    @(negedge clk);
    fa_valid = 1; fa_we = 1;
    @(negedge clk);
    fa_valid = 0; fa_we = 0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic count_ticks(input int len, output int n);
    n = 0;
    for (int i = 0; i < len; i++) begin
      if (ftg_tick) n++;
      @(negedge clk);
    end
  endtask

  task automatic run_op(input logic [7:0] bits, input int ticks, input logic [2:0] code,
                        input logic [7:0] after, input string tag);
    logic [15:0] r;
    int n;
    bwr(A_OPW, {8'hA5, bits});
    fwr();
    check({tag, " op_code"}, op_code, code);
    busy_len(n);
    check({tag, " busy length"}, n, ticks);
    brd(A_OPW, r);
    check({tag, " op word after"}, r, {8'h96, after});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    int n;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    brd(A_OPW, r); check("R1 op word", r, 16'h9600);
    brd(A_TIM, r); check("R1 timing word", r, 16'h9642);
    brd(A_STS, r); check("R1 status word", r, 16'h9600);
    check("R1 busy", busy, 0);
    check("R1 op_code", op_code, 0);

    // one tick per cycle for the sequencing tests
    bwr(A_TIM, 16'hA540);

    // R3 undefined bits read 0
    bwr(A_OPW, 16'hA579);
    brd(A_OPW, r); check("R3 op word masks bits", r, 16'h9640);
    bwr(A_OPW, 16'hA5C0);
    brd(A_OPW, r); check("R3 segwrite pattern", r, 16'h96C0);

    // R4 illegal pattern
    bwr(A_OPW, 16'hA546);
    brd(A_OPW, r); check("R4 op word unchanged", r, 16'h96C0);
    brd(A_STS, r); check("R4 accv set", r[2], 1);
    bwr(A_STS, 16'hA500);
    brd(A_STS, r); check("R12 accv cleared", r, 16'h9600);

    // R2 bad key
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = A_TIM; bus_wdata = 16'h1234;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    check("R2 rst_req pulse", rst_req, 1);
    @(negedge clk);
    check("R2 rst_req one cycle", rst_req, 0);
    brd(A_TIM, r); check("R2 timing unchanged", r, 16'h9640);
    brd(A_STS, r); check("R2 keyv set", r, 16'h9602);
    bwr(A_STS, 16'hA500);
    brd(A_STS, r); check("R12 keyv cleared", r, 16'h9600);

    // R6 flash write with nothing armed
    bwr(A_OPW, 16'hA500);
    fwr();
    check("R6 no busy", busy, 0);
    brd(A_STS, r); check("R6 accv set", r, 16'h9604);

    // R12 set and clear in the same cycle: set wins
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = A_STS; bus_wdata = 16'hA500;
    fa_valid = 1; fa_we = 1;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; fa_valid = 0; fa_we = 0;
    brd(A_STS, r); check("R12 set beats clear", r[2], 1);
    bwr(A_STS, 16'hA500);
    brd(A_STS, r); check("R12 lone clear", r[2], 0);

    // R7 the four operations
    run_op(8'h40, WRT,  3'd1, 8'h40, "R7 write");
    run_op(8'h02, SEGT, 3'd2, 8'h00, "R7 segment erase");
    run_op(8'h04, MAST, 3'd3, 8'h00, "R7 main erase");
    run_op(8'h06, MAST, 3'd4, 8'h00, "R7 full erase");

    // R5 R10 R11 while busy
    bwr(A_OPW, 16'hA502);
    fwr();
    check("R7 busy up", busy, 1);
    fa_rdata_in = 16'hBEEF;
    #1 check("R10 self-jump while busy", fa_rdata_out, 16'h3FFF);
    fa_we = 1;
    #1 check("R11 write not ready", fa_ready, 0);
    fa_we = 0;
    #1 check("R11 read ready", fa_ready, 1);
    bwr(A_TIM, 16'hA5C5);
    bwr(A_OPW, 16'hA540);
    busy_len(n);
    brd(A_TIM, r); check("R5 timing unchanged", r, 16'h9640);
    brd(A_OPW, r); check("R5 op word erase done", r, 16'h9600);
    brd(A_STS, r); check("R5 accv set", r[2], 1);
    bwr(A_STS, 16'hA500);
    #1 check("R10 passthrough idle", fa_rdata_out, 16'hBEEF);

    // R9 emergency exit during a mass erase
    bwr(A_OPW, 16'hA506);
    fwr();
    repeat (3) @(negedge clk);
    bwr(A_STS, 16'hA520);
    check("R9 busy dropped", busy, 0);
    brd(A_OPW, r); check("R9 erase bits cleared", r, 16'h9600);

    // R8 source select and divide
    for (int k = 0; k < 6; k++) begin
      logic [5:0] fn;
      fn = (k == 0) ? 6'd63 : 6'($urandom_range(0, 20));
      bwr(A_TIM, {8'hA5, 2'b01, fn});
      bwr(A_STS, 16'hA520);
      count_ticks(8 * (fn + 1), n);
      check("R8 divide ratio", n, 8);
    end
    bwr(A_TIM, 16'hA503);     // aclk source, idle
    bwr(A_STS, 16'hA520);
    count_ticks(40, n);
    check("R8 aclk select quiet", n, 0);
    mclk_en = 0; smclk_en = 1;
    bwr(A_TIM, 16'hA5C1);     // source 3, divide by 2
    bwr(A_STS, 16'hA520);
    count_ticks(16, n);
    check("R8 smclk select", n, 8);
    mclk_en = 1; smclk_en = 0;
    bwr(A_TIM, 16'hA540);

    // random writes against the bench model (R2 R4)
    for (int i = 0; i < 60; i++) begin
      logic [7:0] b, cur;
      bit good, sel_tim;
      b = 8'($urandom);
      good = ($urandom_range(0, 4) != 0);
      sel_tim = ($urandom_range(0, 1) == 1) && (i > 0);
      brd(A_OPW, r); cur = r[7:0];
      if (sel_tim) begin
        bwr(A_TIM, {good ? 8'hA5 : 8'h5A, b});
        brd(A_TIM, r);
        check("R2 random timing", r, good ? {8'h96, b} : 16'h9640);
        bwr(A_TIM, 16'hA540);
      end else begin
        bwr(A_OPW, {good ? 8'hA5 : 8'h33, b});
        brd(A_OPW, r);
        check("R4 random op word", r,
              {8'h96, (good && exp_legal(b)) ? opw_view(b) : cur});
        brd(A_STS, r);
        check("R4 random flags", r[2:1], {good && !exp_legal(b), !good});
      end
      bwr(A_STS, 16'hA500);
    end

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule